// File: doc/BRIEF.md
# PIR Sensor Serial Settings Engine

This block loads the configuration of a passive-infrared motion sensor over a two-wire bit-serial link. One line carries the serial clock and the other line carries data in both directions. On a write request it takes a detection threshold, a gain level and a band-pass filter type from its control port, turns them into a fixed-length settings frame, and shifts the frame out one bit per clock period. On a read request it clocks the sensor's settings back out and collects them into a 48-bit word. The host side can then compare that word with what it wrote.

Every transfer ends with a fixed quiet interval. During this interval the link is held idle before the block reports completion. The clock half-period and the quiet interval are both parameters counted in system-clock ticks. The defaults give a 1 kHz serial clock and a 30 ms quiet time at 250 MHz. The block drives both lines through separate output-enable signals, so a pad ring can build the tristate buffers.

A transfer is started by a one-cycle request. The block ignores further requests until the transfer, including its quiet interval, has finished. Completion is marked by a one-cycle done pulse.

Top module: `pir_settings_link`

## Requirements
- R1: A write produces exactly 52 rising edges of the serial clock, with both lines driven. Settings positions 1 through 47 are sent first, one per edge in ascending order. They are followed by the trailer bits 0, 1, 1, 0, 1 (the value 0b10110 sent from its least-significant bit). Position 0 is never sent, and every position that is not part of a field is sent as 0.
- R2: The 8-bit threshold occupies settings positions 10 to 17, with its least-significant bit at position 10.
- R3: The 2-bit gain level occupies positions 19 and 20, least-significant bit at position 19. Level 1 encodes as 1, level 2 as 3 and level 3 as 0. An input level of 0 is encoded like level 1.
- R4: The 3-bit filter code occupies positions 21 to 23, least-significant bit at position 21. The filter-type input values 0, 1, 2 and 3 (types A, B, C and D) encode as 7, 0, 1 and 2.
- R5: A read produces exactly 48 rising edges with the data output released. The data input is sampled on the last system-clock tick of each high phase. Bit k of the read word holds the value taken at edge k, counting from 0. Bit 0 is always 0.
- R6: Each bit period is a low phase of HALF_TICKS cycles followed by a high phase of HALF_TICKS cycles. During a write, the data line only changes while the clock is low.
- R7: After the last falling clock edge of a transfer, the clock stays low with no edges for QUIET_TICKS cycles. The done pulse follows in the next cycle.
- R8: done is high for exactly one cycle per transfer. busy is high from the cycle after a request until done, and it is low while done is high.
- R9: A request that arrives while busy is ignored. Changing the settings inputs during a transfer has no effect on the frame being sent.
- R10: In reset and while idle, the clock is low and both output enables are low. After reset, busy, done and the read word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle transfer request, accepted only when idle |
| rd_mode_i | input | 1 | Transfer direction: 1 for read, 0 for write |
| thresh_i | input | 8 | Detection threshold |
| gain_lvl_i | input | 2 | Gain level, 1 to 3 |
| filt_type_i | input | 2 | Filter type index, 0 to 3 for A to D |
| sclk_o | output | 1 | Serial clock level |
| sclk_oe_o | output | 1 | Serial clock output enable |
| sdata_o | output | 1 | Serial data output level |
| sdata_oe_o | output | 1 | Serial data output enable |
| sdata_i | input | 1 | Serial data input from the pad |
| rdata_o | output | 48 | Settings word read back, bit k = position k |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check the link-level behaviour on every cycle:
- the clock and data enable are quiet while idle;
- data is stable while the clock is high;
- the data enable only appears together with the clock enable;
- busy persists until done;
- done is a single cycle that lands in idle.

The bench scenarios are needed for everything that depends on content or counting:
- the placement and encoding of each field;
- the trailer;
- the number of clock edges per direction;
- the exact phase lengths and quiet interval;
- forcing bit 0 of the read word to 0;
- the rejection of a second request in the middle of a transfer.

// File: rtl/pir_link_pkg.sv
package pir_link_pkg;

  localparam int unsigned MAP_BITS  = 48;
  localparam int unsigned TRL_BITS  = 5;
  localparam int unsigned WR_BITS   = MAP_BITS - 1 + TRL_BITS;
  localparam logic [TRL_BITS-1:0] TRAILER = 5'b10110;

  localparam int unsigned TH_POS = 10;
  localparam int unsigned TH_W   = 8;
  localparam int unsigned GN_POS = 19;
  localparam int unsigned GN_W   = 2;
  localparam int unsigned FT_POS = 21;
  localparam int unsigned FT_W   = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LO    = 2'd1,
    ST_HI    = 2'd2,
    ST_QUIET = 2'd3
  } link_state_e;

  function automatic logic [GN_W-1:0] gain_code(input logic [1:0] lvl);
    case (lvl)
      2'd2:    gain_code = 2'd3;
      2'd3:    gain_code = 2'd0;
      default: gain_code = 2'd1;
    endcase
  endfunction

  function automatic logic [FT_W-1:0] filt_code(input logic [1:0] typ);
    case (typ)
      2'd0:    filt_code = 3'd7;
      2'd1:    filt_code = 3'd0;
      2'd2:    filt_code = 3'd1;
      default: filt_code = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/pir_frame_build.sv
module pir_frame_build
  import pir_link_pkg::*;
(
  input  logic [TH_W-1:0]    thresh_i,
  input  logic [1:0]         gain_lvl_i,
  input  logic [1:0]         filt_type_i,
  output logic [WR_BITS-1:0] frame_o
);
  // Frame bit k carries settings position k+1; the trailer follows position 47.
  localparam int unsigned TH_IDX = TH_POS - 1;
  localparam int unsigned GN_IDX = GN_POS - 1;
  localparam int unsigned FT_IDX = FT_POS - 1;
  localparam int unsigned TR_IDX = MAP_BITS - 1;

  always_comb begin
    frame_o                    = '0;
    frame_o[TH_IDX +: TH_W]    = thresh_i;
    frame_o[GN_IDX +: GN_W]    = gain_code(gain_lvl_i);
    frame_o[FT_IDX +: FT_W]    = filt_code(filt_type_i);
    frame_o[TR_IDX +: TRL_BITS] = TRAILER;
  end

endmodule

// File: rtl/pir_phase_timer.sv
module pir_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)
      cnt_d = load_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/pir_rx_capture.sv
module pir_rx_capture #(
  parameter int unsigned WIDTH = 48,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             sdin_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    for (int k = 0; k < int'(WIDTH); k++) begin
      if (sample_en_i && (idx_i == IDX_W'(k)))
        word_d[k] = (k == 0) ? 1'b0 : sdin_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

endmodule

// File: rtl/pir_settings_link.sv
module pir_settings_link
  import pir_link_pkg::*;
#(
  parameter int unsigned HALF_TICKS  = 125000,
  parameter int unsigned QUIET_TICKS = 7500000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                rd_mode_i,
  input  logic [7:0]          thresh_i,
  input  logic [1:0]          gain_lvl_i,
  input  logic [1:0]          filt_type_i,
  output logic                sclk_o,
  output logic                sclk_oe_o,
  output logic                sdata_o,
  output logic                sdata_oe_o,
  input  logic                sdata_i,
  output logic [MAP_BITS-1:0] rdata_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned T_MAX = (QUIET_TICKS > HALF_TICKS) ? QUIET_TICKS : HALF_TICKS;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);
  localparam int unsigned BIT_W = $clog2(WR_BITS);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_TICKS - 1);
  localparam logic [CNT_W-1:0] QUIET_LD = CNT_W'(QUIET_TICKS - 1);
  localparam logic [BIT_W-1:0] WR_LAST  = BIT_W'(WR_BITS - 1);
  localparam logic [BIT_W-1:0] RD_LAST  = BIT_W'(MAP_BITS - 1);

  link_state_e        state_q, state_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               rd_q, rd_d;
  logic [WR_BITS-1:0] tx_q, tx_d;
  logic               done_q, done_d;

  logic [WR_BITS-1:0] frame;
  logic               restart;
  logic [CNT_W-1:0]   load;
  logic               expire;
  logic               last_bit;
  logic               sample_en;

  pir_frame_build i_frame (
    .thresh_i    (thresh_i),
    .gain_lvl_i  (gain_lvl_i),
    .filt_type_i (filt_type_i),
    .frame_o     (frame)
  );

  pir_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .load_i    (load),
    .expire_o  (expire)
  );

  pir_rx_capture #(.WIDTH(MAP_BITS), .IDX_W(BIT_W)) i_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en_i (sample_en),
    .idx_i       (bit_q),
    .sdin_i      (sdata_i),
    .word_o      (rdata_o)
  );

  assign last_bit  = (bit_q == (rd_q ? RD_LAST : WR_LAST));
  assign sample_en = (state_q == ST_HI) && expire && rd_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    rd_d    = rd_q;
    tx_d    = tx_q;
    done_d  = 1'b0;
    restart = 1'b0;
    load    = HALF_LD;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LO;
          rd_d    = rd_mode_i;
          tx_d    = frame;
          bit_d   = '0;
          restart = 1'b1;
        end
      end
      ST_LO: begin
        if (expire) begin
          state_d = ST_HI;
          restart = 1'b1;
        end
      end
      ST_HI: begin
        if (expire) begin
          restart = 1'b1;
          if (last_bit) begin
            state_d = ST_QUIET;
            load    = QUIET_LD;
          end else begin
            state_d = ST_LO;
            bit_d   = bit_q + 1'b1;
            tx_d    = {1'b0, tx_q[WR_BITS-1:1]};
          end
        end
      end
      default: begin
        if (expire) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      tx_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      rd_q    <= rd_d;
      tx_q    <= tx_d;
      done_q  <= done_d;
    end
  end

  assign sclk_o     = (state_q == ST_HI);
  assign sclk_oe_o  = (state_q != ST_IDLE);
  assign sdata_oe_o = !rd_q && ((state_q == ST_LO) || (state_q == ST_HI));
  assign sdata_o    = sdata_oe_o && tx_q[0];
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

endmodule

// File: rtl/pir_settings_link_chk.sv
module pir_settings_link_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_o,
  input logic sclk_oe_o,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic busy_o,
  input logic done_o
);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !sdata_oe_o && !sclk_oe_o));

  p_data_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o) && sdata_oe_o) |-> $stable(sdata_o));

  p_data_oe_with_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe_o |-> sclk_oe_o);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_in_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !sclk_o));

  p_busy_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

endmodule

bind pir_settings_link pir_settings_link_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_o     (sclk_o),
  .sclk_oe_o  (sclk_oe_o),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/test_pir_settings_link.sv
module test_pir_settings_link;

  localparam int HALF  = 3;
  localparam int QUIET = 40;
  localparam int NVEC  = 7;

  // {rd, thresh[7:0], gain[1:0], filt[1:0], seed[15:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 8'd56,   2'd2, 2'd1, 16'h0000},
    {1'b0, 8'hFF,   2'd3, 2'd0, 16'h0000},
    {1'b0, 8'h00,   2'd1, 2'd3, 16'h0000},
    {1'b0, 8'hA5,   2'd0, 2'd2, 16'h0000},
    {1'b1, 8'h00,   2'd0, 2'd0, 16'hC3A5},
    {1'b1, 8'h00,   2'd0, 2'd0, 16'hFFFF},
    {1'b1, 8'h00,   2'd0, 2'd0, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_mode_i = 1'b0;
  logic [7:0]  thresh_i = '0;
  logic [1:0]  gain_lvl_i = '0;
  logic [1:0]  filt_type_i = '0;
  logic        sdata_i = 1'b0;
  logic        sclk_o, sclk_oe_o, sdata_o, sdata_oe_o, busy_o, done_o;
  logic [47:0] rdata_o;

  pir_settings_link #(.HALF_TICKS(HALF), .QUIET_TICKS(QUIET)) i_pir_settings_link (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_mode_i(rd_mode_i),
    .thresh_i(thresh_i), .gain_lvl_i(gain_lvl_i), .filt_type_i(filt_type_i),
    .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .sdata_i(sdata_i), .rdata_o(rdata_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Monitor state
  bit          mon_en = 1'b0;
  bit          cur_rd = 1'b0;
  logic [47:0] rpat = '0;
  logic [63:0] cap = '0;
  int cyc = 0, rise_cnt = 0, hi_len = 0, lo_len = 0;
  int timing_err = 0, oe_err = 0, last_fall = 0, done_cyc = 0, done_hi = 0;
  logic prev_sclk = 1'b0, prev_sdata = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (sclk_o && !prev_sclk) begin
        if (lo_len != HALF) timing_err++;
        if (rise_cnt < 64) cap[rise_cnt] = sdata_o;
        if (sdata_oe_o != !cur_rd) oe_err++;
        if (cur_rd && rise_cnt < 48) sdata_i = rpat[rise_cnt];
        rise_cnt++;
        hi_len = 1;
      end else if (sclk_o) begin
        hi_len++;
        if (!cur_rd && sdata_o != prev_sdata) timing_err++;
      end else if (prev_sclk) begin
        if (hi_len != HALF) timing_err++;
        lo_len = 1;
        last_fall = cyc;
      end else if (busy_o) begin
        lo_len++;
      end
      if (done_o) begin
        if (done_hi == 0) done_cyc = cyc;
        done_hi++;
      end
    end
    prev_sclk  = sclk_o;
    prev_sdata = sdata_o;
  end

  function automatic logic [1:0] exp_gain(input logic [1:0] g);
    case (g) 2'd2: return 2'd3; 2'd3: return 2'd0; default: return 2'd1; endcase
  endfunction

  function automatic logic [2:0] exp_filt(input logic [1:0] f);
    case (f) 2'd0: return 3'd7; 2'd1: return 3'd0; 2'd2: return 3'd1; default: return 3'd2; endcase
  endfunction

  // Bit sent at edge k corresponds to position k+1 for k < 47.
  function automatic logic [7:0] got_field(input int pos, input int w);
    logic [7:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = cap[pos - 1 + i];
    return r;
  endfunction

  task automatic xfer(input bit rd, input logic [7:0] th, input logic [1:0] g,
                      input logic [1:0] f, input logic [15:0] seed, input int poke);
    int n;
    logic [47:0] exp_rd;
    logic [63:0] rest;
    @(posedge clk); #1;
    rd_mode_i = rd; thresh_i = th; gain_lvl_i = g; filt_type_i = f;
    rpat = {seed, ~seed, seed ^ 16'h5A3C};
    cur_rd = rd; cap = '0; rise_cnt = 0; hi_len = 0; lo_len = 0;
    timing_err = 0; oe_err = 0; done_hi = 0; last_fall = 0; done_cyc = 0;
    mon_en = 1'b1;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    n = 0;
    while (done_hi == 0 && n < 2000) begin
      @(posedge clk); #1;
      n++;
      if (poke > 0 && n == poke) begin
        start_i = 1'b1; rd_mode_i = ~rd; thresh_i = ~th; gain_lvl_i = ~g; filt_type_i = ~f;
        @(posedge clk); #1;
        start_i = 1'b0;
      end
    end
    repeat (3) @(posedge clk);
    #1;
    mon_en = 1'b0;
    chk(n < 2000, "R8 done reached", 64'(n), 64'd0);
    chk(done_hi == 1, "R8 done width", 64'(done_hi), 64'd1);
    chk(!busy_o, "R8 busy after done", 64'(busy_o), 64'd0);
    chk(timing_err == 0, "R6 phase timing", 64'(timing_err), 64'd0);
    chk(done_cyc - last_fall == QUIET, "R7 quiet time", 64'(done_cyc - last_fall), 64'(QUIET));
    if (rd) begin
      exp_rd = {rpat[47:1], 1'b0};
      chk(rise_cnt == 48, "R5 read edge count", 64'(rise_cnt), 64'd48);
      chk(oe_err == 0, "R5 data released", 64'(oe_err), 64'd0);
      chk(rdata_o == exp_rd, "R5 read word", 64'(rdata_o), 64'(exp_rd));
    end else begin
      chk(rise_cnt == 52, "R1 write edge count", 64'(rise_cnt), 64'd52);
      chk(oe_err == 0, "R1 lines driven", 64'(oe_err), 64'd0);
      chk(got_field(10, 8) == th, "R2 threshold field", 64'(got_field(10, 8)), 64'(th));
      chk(got_field(19, 2) == 8'(exp_gain(g)), "R3 gain code", 64'(got_field(19, 2)), 64'(exp_gain(g)));
      chk(got_field(21, 3) == 8'(exp_filt(f)), "R4 filter code", 64'(got_field(21, 3)), 64'(exp_filt(f)));
      rest = cap;
      for (int p = 10; p <= 23; p++) if (p != 18) rest[p - 1] = 1'b0;
      chk(rest == {12'h0, 5'b10110, 47'h0}, "R1 zeros and trailer", rest, {12'h0, 5'b10110, 47'h0});
    end
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(!busy_o && !done_o && !sclk_o && !sclk_oe_o && !sdata_oe_o, "R10 outputs in reset",
        {59'h0, busy_o, done_o, sclk_o, sclk_oe_o, sdata_oe_o}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(rdata_o == '0 && !busy_o && !sclk_oe_o, "R10 idle after reset", 64'(rdata_o), 64'd0);

    for (int i = 0; i < NVEC; i++)
      xfer(VEC[i][28], VEC[i][27:20], VEC[i][19:18], VEC[i][17:16], VEC[i][15:0], 0);

    // R9: second request mid-write with changed settings is ignored
    xfer(1'b0, 8'h3C, 2'd2, 2'd0, 16'h0, 60);

    // R10: reset in the middle of a transfer releases the lines
    @(posedge clk); #1;
    rd_mode_i = 1'b0; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk(!busy_o && !sclk_o && !sclk_oe_o && !sdata_oe_o, "R10 reset mid-transfer",
        {60'h0, busy_o, sclk_o, sclk_oe_o, sdata_oe_o}, 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule